// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the strobes and port drive values that an 8-bit microcontroller uses to talk to external code and data memory. A machine cycle is six states long, and each state is split into two halves of one oscillator clock. The block therefore sees twelve slots per machine cycle. The instruction sequencer supplies the current state and half, plus a description of the access planned for the cycle: its kind, address and write byte. From these the block generates the following outputs:

- the address-latch pulse;
- the active-low code-read strobe;
- the active-low data read and write strobes;
- the multiplexed low-address/data port value and its drive enable;
- the high-address port value, with a flag that tells whether that port shows an address or its own register contents.

The address-latch pulse runs freely, two pulses per machine cycle, so it can be used as a clock output at one sixth of the oscillator rate. A data access consumes one of those pulses. A disable input stops the free-running pulses but still lets through the pulses that external data moves and code-table reads need. Instruction decoding and the memories themselves lie outside this block.

Top module: `ebus_strobe_top`

## Requirements
- R1: The slot index is 2*state+half (0..11). The access descriptor (kind, address, write byte) is sampled in slot 0 and governs the whole machine cycle. All outputs are registered: the values after a clock edge belong to the slot presented before that edge. Kind codes are 0 none, 1 code fetch, 2 table read, 3 read with 16-bit pointer, 4 write with 16-bit pointer, 5 read with 8-bit pointer, 6 write with 8-bit pointer, and 7 behaves as none.
- R2: With the disable input low, the address-latch output is high in slots 1, 2, 7 and 8 of cycles of kind none, fetch or table read. This gives one pulse every six clocks.
- R3: In a data cycle (kinds 3 to 6), the address-latch output is high only in slots 1 and 2. The second pulse of that cycle is skipped.
- R4: With the disable input high, the address-latch output stays low in cycles of kind none or fetch. Data cycles still pulse in slots 1 and 2, and table reads still pulse in slots 1, 2, 7 and 8.
- R5: In fetch and table-read cycles, the code-read strobe is low in slots 3 to 5 and 9 to 11 (two pulses). It stays high through every other kind of cycle.
- R6: The read strobe is low in slots 4 to 9 of kinds 3 and 5. The write strobe is low in slots 4 to 9 of kinds 4 and 6. Neither is ever low together with the other or with the code-read strobe.
- R7: In every access cycle (fetch, table read or data), port 0 drives the low address byte in slots 1 and 2. Fetch and table-read cycles drive the low byte of address+1 in slots 7 and 8. Write cycles drive the write byte in slots 3 to 10. At all other times port 0 is undriven and its value reads 0.
- R8: In fetch and table-read cycles, port 2 shows the high byte of the address in slots 0 to 5 and the high byte of address+1 in slots 6 to 11. In 16-bit-pointer data cycles it shows the address high byte in every slot. In all of these cases the address flag is 1. In 8-bit-pointer and idle cycles it passes the live register input and the flag is 0.
- R9: During reset the address-latch output is 0, all three strobes are 1, port 0 is undriven with value 0, and port 2 shows 0 with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| mc_state_i | input | 3 | Machine-cycle state, 0..5 |
| mc_half_i | input | 1 | Half of the current state |
| acc_kind_i | input | 3 | Access kind code, sampled in slot 0 |
| acc_addr_i | input | ADDR_W | Access address, sampled in slot 0 |
| acc_wdata_i | input | DATA_W | Write byte, sampled in slot 0 |
| p2_sfr_i | input | ADDR_W-DATA_W | Port 2 register contents |
| ale_off_i | input | 1 | Free-running address-latch disable |
| ale_o | output | 1 | Address-latch pulse |
| psen_n_o | output | 1 | Code-read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p0_out_o | output | DATA_W | Port 0 drive value |
| p0_oe_o | output | 1 | Port 0 drive enable |
| p2_out_o | output | ADDR_W-DATA_W | Port 2 value |
| p2_addr_o | output | 1 | Port 2 shows an address |

## Verification
The bench aims at the following corner cases, each compared on every clock against a behavioural model:

- **Skipped second pulse in data cycles.** A design that ignored the skip would keep toggling the latch during the data phase and corrupt the latched address.
- **Disable exemptions.** Data moves and table reads must still pulse with the disable input high. A design that gated every pulse would leave external data moves with no latched address.
- **Second fetch crossing a page (0x12FF) and wrapping at 0xFFFF.** A design that kept the first high byte would fetch the second byte from the wrong page.
- **Address and kind changing outside slot 0.** A design that did not hold its descriptor would change strobes in the middle of a cycle.
- **8-bit-pointer cycles with a changing register input.** A design that drove the address there would overwrite the port contents.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_FETCH = 3'd1,
        ACC_TABLE = 3'd2,
        ACC_RD_W  = 3'd3,
        ACC_WR_W  = 3'd4,
        ACC_RD_N  = 3'd5,
        ACC_WR_N  = 3'd6,
        ACC_RSVD  = 3'd7
    } acc_kind_e;

    localparam int SLOT_W = 4;

    // slot windows inside the 12-slot machine cycle
    localparam logic [SLOT_W-1:0] LATCH_A0 = 4'd1;
    localparam logic [SLOT_W-1:0] LATCH_A1 = 4'd2;
    localparam logic [SLOT_W-1:0] LATCH_B0 = 4'd7;
    localparam logic [SLOT_W-1:0] LATCH_B1 = 4'd8;
    localparam logic [SLOT_W-1:0] HALF_MID = 4'd6;
    localparam logic [SLOT_W-1:0] DSTB_LO  = 4'd4;
    localparam logic [SLOT_W-1:0] DSTB_HI  = 4'd9;
    localparam logic [SLOT_W-1:0] WDRV_LO  = 4'd3;
    localparam logic [SLOT_W-1:0] WDRV_HI  = 4'd10;
    localparam logic [SLOT_W-1:0] LAST_SLOT = 4'd11;

    function automatic logic kind_is_code(acc_kind_e k);
        return (k == ACC_FETCH) || (k == ACC_TABLE);
    endfunction

    function automatic logic kind_is_data(acc_kind_e k);
        return (k == ACC_RD_W) || (k == ACC_WR_W) || (k == ACC_RD_N) || (k == ACC_WR_N);
    endfunction

    function automatic logic kind_is_read(acc_kind_e k);
        return (k == ACC_RD_W) || (k == ACC_RD_N);
    endfunction

    function automatic logic kind_is_write(acc_kind_e k);
        return (k == ACC_WR_W) || (k == ACC_WR_N);
    endfunction

    function automatic logic kind_is_wide(acc_kind_e k);
        return (k == ACC_RD_W) || (k == ACC_WR_W);
    endfunction

endpackage

// File: rtl/ebus_cycle_track.sv
module ebus_cycle_track
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mc_state_i,
    input  logic              mc_half_i,
    input  logic [2:0]        acc_kind_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    output logic [SLOT_W-1:0] slot_o,
    output acc_kind_e         kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    typedef struct packed {
        acc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } desc_t;

    desc_t desc_d, desc_q;
    logic  cycle_start;

    always_comb begin
        slot_o      = {mc_state_i, mc_half_i};
        cycle_start = (slot_o == '0);
        desc_d      = desc_q;
        if (cycle_start) begin
            desc_d.kind  = acc_kind_e'(acc_kind_i);
            desc_d.addr  = acc_addr_i;
            desc_d.wdata = acc_wdata_i;
        end
        // slot 0 already acts on the fresh descriptor
        kind_o  = desc_d.kind;
        addr_o  = desc_d.addr;
        wdata_o = desc_d.wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q <= '{kind: ACC_NONE, addr: '0, wdata: '0};
        end else begin
            desc_q <= desc_d;
        end
    end

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    input  acc_kind_e         kind_i,
    input  logic              ale_off_i,
    output logic              ale_o,
    output logic              psen_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o
);

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    strobe_t st_d, st_q;
    logic    win_a, win_b, code_win, data_win, ale_allowed;

    always_comb begin
        win_a    = (slot_i == LATCH_A0) || (slot_i == LATCH_A1);
        win_b    = (slot_i == LATCH_B0) || (slot_i == LATCH_B1);
        code_win = ((slot_i > LATCH_A1) && (slot_i < HALF_MID)) ||
                   ((slot_i > LATCH_B1) && (slot_i <= LAST_SLOT));
        data_win = (slot_i >= DSTB_LO) && (slot_i <= DSTB_HI);

        st_d        = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
        ale_allowed = 1'b0;

        if (kind_is_data(kind_i)) begin
            // address pulse kept, second pulse given up for the data phase
            st_d.ale  = win_a;
            st_d.rd_n = !(kind_is_read(kind_i) && data_win);
            st_d.wr_n = !(kind_is_write(kind_i) && data_win);
        end else if (kind_is_code(kind_i)) begin
            ale_allowed = !ale_off_i || (kind_i == ACC_TABLE);
            st_d.ale    = ale_allowed && (win_a || win_b);
            st_d.psen_n = !code_win;
        end else begin
            st_d.ale = !ale_off_i && (win_a || win_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ale_o    = st_q.ale;
    assign psen_n_o = st_q.psen_n;
    assign rd_n_o   = st_q.rd_n;
    assign wr_n_o   = st_q.wr_n;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R6
    AST_CODE_DATA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n_o |-> (rd_n_o && wr_n_o)); // R6
    AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n_o) |=> !psen_n_o); // R5
    AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale_o) |=> ale_o); // R2

endmodule

// File: rtl/ebus_port_mux.sv
module ebus_port_mux
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOT_W-1:0]        slot_i,
    input  acc_kind_e                kind_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [ADDR_W-DATA_W-1:0] p2_sfr_i,
    output logic [DATA_W-1:0]        p0_out_o,
    output logic                     p0_oe_o,
    output logic [ADDR_W-DATA_W-1:0] p2_out_o,
    output logic                     p2_addr_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] p0;
        logic              p0_oe;
        logic [HI_W-1:0]   p2;
        logic              p2_addr;
    } port_t;

    port_t             pt_d, pt_q;
    logic [ADDR_W-1:0] addr_next;
    logic              win_a, win_b, wdrv_win;

    always_comb begin
        addr_next = addr_i + ADDR_W'(1);
        win_a     = (slot_i == LATCH_A0) || (slot_i == LATCH_A1);
        win_b     = (slot_i == LATCH_B0) || (slot_i == LATCH_B1);
        wdrv_win  = (slot_i >= WDRV_LO) && (slot_i <= WDRV_HI);

        pt_d = '{p0: '0, p0_oe: 1'b0, p2: p2_sfr_i, p2_addr: 1'b0};

        if (kind_is_code(kind_i)) begin
            if (win_a) begin
                pt_d.p0    = addr_i[DATA_W-1:0];
                pt_d.p0_oe = 1'b1;
            end else if (win_b) begin
                pt_d.p0    = addr_next[DATA_W-1:0];
                pt_d.p0_oe = 1'b1;
            end
            pt_d.p2      = (slot_i < HALF_MID) ? addr_i[ADDR_W-1:DATA_W]
                                               : addr_next[ADDR_W-1:DATA_W];
            pt_d.p2_addr = 1'b1;
        end else if (kind_is_data(kind_i)) begin
            if (win_a) begin
                pt_d.p0    = addr_i[DATA_W-1:0];
                pt_d.p0_oe = 1'b1;
            end else if (kind_is_write(kind_i) && wdrv_win) begin
                pt_d.p0    = wdata_i;
                pt_d.p0_oe = 1'b1;
            end
            if (kind_is_wide(kind_i)) begin
                pt_d.p2      = addr_i[ADDR_W-1:DATA_W];
                pt_d.p2_addr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '{p0: '0, p0_oe: 1'b0, p2: '0, p2_addr: 1'b0};
        end else begin
            pt_q <= pt_d;
        end
    end

    assign p0_out_o  = pt_q.p0;
    assign p0_oe_o   = pt_q.p0_oe;
    assign p2_out_o  = pt_q.p2;
    assign p2_addr_o = pt_q.p2_addr;

    AST_P0_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_oe_o |-> (p0_out_o == '0)); // R7

endmodule

// File: rtl/ebus_strobe_top.sv
module ebus_strobe_top
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               mc_state_i,
    input  logic                     mc_half_i,
    input  logic [2:0]               acc_kind_i,
    input  logic [ADDR_W-1:0]        acc_addr_i,
    input  logic [DATA_W-1:0]        acc_wdata_i,
    input  logic [ADDR_W-DATA_W-1:0] p2_sfr_i,
    input  logic                     ale_off_i,
    output logic                     ale_o,
    output logic                     psen_n_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic [DATA_W-1:0]        p0_out_o,
    output logic                     p0_oe_o,
    output logic [ADDR_W-DATA_W-1:0] p2_out_o,
    output logic                     p2_addr_o
);

    logic [SLOT_W-1:0] slot;
    acc_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    ebus_cycle_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_state_i (mc_state_i),
        .mc_half_i  (mc_half_i),
        .acc_kind_i (acc_kind_i),
        .acc_addr_i (acc_addr_i),
        .acc_wdata_i(acc_wdata_i),
        .slot_o     (slot),
        .kind_o     (kind),
        .addr_o     (addr),
        .wdata_o    (wdata)
    );

    ebus_strobe_gen u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_i   (slot),
        .kind_i   (kind),
        .ale_off_i(ale_off_i),
        .ale_o    (ale_o),
        .psen_n_o (psen_n_o),
        .rd_n_o   (rd_n_o),
        .wr_n_o   (wr_n_o)
    );

    ebus_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_i   (slot),
        .kind_i   (kind),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .p2_sfr_i (p2_sfr_i),
        .p0_out_o (p0_out_o),
        .p0_oe_o  (p0_oe_o),
        .p2_out_o (p2_out_o),
        .p2_addr_o(p2_addr_o)
    );

    // strobes and port 0 come from separate submodules
    AST_RD_FLOATS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !p0_oe_o); // R7
    AST_PSEN_FLOATS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n_o |-> !p0_oe_o); // R7
    AST_WR_DRIVES_P0: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> p0_oe_o); // R6
    AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n_o) || $fell(wr_n_o)) |-> !ale_o); // R3

endmodule

// File: tb/tb_ebus_strobe_top.sv
module tb_ebus_strobe_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mc_state_i = '0;
    logic          mc_half_i = 1'b0;
    logic [2:0]    acc_kind_i = '0;
    logic [AW-1:0] acc_addr_i = '0;
    logic [DW-1:0] acc_wdata_i = '0;
    logic [7:0]    p2_sfr_i = '0;
    logic          ale_off_i = 1'b0;
    logic          ale_o, psen_n_o, rd_n_o, wr_n_o, p0_oe_o, p2_addr_o;
    logic [7:0]    p0_out_o, p2_out_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    int m_kind = 0;
    int m_addr = 0;
    int m_wd = 0;
    int e_ale, e_psen, e_rd, e_wr, e_p0, e_p0oe, e_p2, e_p2a;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_strobe_top dut (
        .clk(clk), .rst_n(rst_n), .mc_state_i(mc_state_i), .mc_half_i(mc_half_i),
        .acc_kind_i(acc_kind_i), .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i),
        .p2_sfr_i(p2_sfr_i), .ale_off_i(ale_off_i), .ale_o(ale_o), .psen_n_o(psen_n_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .p0_out_o(p0_out_o), .p0_oe_o(p0_oe_o),
        .p2_out_o(p2_out_o), .p2_addr_o(p2_addr_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural model of one slot, evaluated from the values presented before the edge
    task automatic model(input int s, input int kin, input int ain, input int win,
                         input int sfr, input bit off);
        bit code, data, rdk, wrk, wide, pa, pb;
        if (s == 0) begin
            m_kind = kin; m_addr = ain; m_wd = win;   // R1 capture in slot 0
        end
        code = (m_kind == 1) || (m_kind == 2);
        data = (m_kind >= 3) && (m_kind <= 6);
        rdk  = (m_kind == 3) || (m_kind == 5);
        wrk  = (m_kind == 4) || (m_kind == 6);
        wide = (m_kind == 3) || (m_kind == 4);
        pa   = (s == 1) || (s == 2);
        pb   = (s == 7) || (s == 8);
        if (data)      e_ale = pa;                                  // R3
        else if (code) e_ale = (pa || pb) && (!off || m_kind == 2); // R2 R4
        else           e_ale = (pa || pb) && !off;
        e_psen = !(code && ((s >= 3 && s <= 5) || s >= 9));
        e_rd   = !(rdk && s >= 4 && s <= 9);
        e_wr   = !(wrk && s >= 4 && s <= 9);
        e_p0 = 0; e_p0oe = 0;
        if ((code || data) && pa) begin
            e_p0 = m_addr % 256; e_p0oe = 1;
        end else if (code && pb) begin
            e_p0 = (m_addr + 1) % 256; e_p0oe = 1;
        end else if (wrk && s >= 3 && s <= 10) begin
            e_p0 = m_wd; e_p0oe = 1;
        end
        if (code) begin
            e_p2 = (s < 6) ? (m_addr / 256) : (((m_addr + 1) % 65536) / 256);
            e_p2a = 1;
        end else if (wide) begin
            e_p2 = m_addr / 256; e_p2a = 1;
        end else begin
            e_p2 = sfr; e_p2a = 0;
        end
    endtask

    task automatic compare_all(input bit off);
        string at;
        if (off) at = "R4";
        else if (m_kind >= 3 && m_kind <= 6) at = "R3";
        else at = "R2";
        chk(at,   "ale",    int'(ale_o),    e_ale);
        chk("R5", "psen_n", int'(psen_n_o), e_psen);
        chk("R6", "rd_n",   int'(rd_n_o),   e_rd);
        chk("R6", "wr_n",   int'(wr_n_o),   e_wr);
        chk("R7", "p0_oe",  int'(p0_oe_o),  e_p0oe);
        chk("R7", "p0_out", int'(p0_out_o), e_p0);
        chk("R8", "p2_out", int'(p2_out_o), e_p2);
        chk("R8", "p2_addr",int'(p2_addr_o),e_p2a);
    endtask

    // one machine cycle; descriptor inputs hold junk outside slot 0 (R1)
    task automatic run_mc(input int kind, input int addr, input int wd, input bit off);
        for (int s = 0; s < 12; s++) begin
            mc_state_i = 3'(s / 2);
            mc_half_i  = 1'(s % 2);
            ale_off_i  = off;
            p2_sfr_i   = 8'($urandom);
            if (s == 0) begin
                acc_kind_i = 3'(kind); acc_addr_i = 16'(addr); acc_wdata_i = 8'(wd);
            end else begin
                acc_kind_i = 3'($urandom); acc_addr_i = 16'($urandom); acc_wdata_i = 8'($urandom);
            end
            @(posedge clk);
            model(s, int'(acc_kind_i), int'(acc_addr_i), int'(acc_wdata_i), int'(p2_sfr_i), off);
            @(negedge clk);
            compare_all(off);
        end
    endtask

    int kinds[10] = '{0, 1, 1, 2, 3, 4, 5, 6, 7, 0};
    int addrs[10] = '{16'h1234, 16'h12FF, 16'hFFFF, 16'h3456, 16'hA5C3,
                      16'h0F0F, 16'h0077, 16'h00E1, 16'h5555, 16'h0000};
    int wdats[10] = '{0, 0, 0, 0, 0, 16'h5A, 0, 16'hC3, 0, 0};

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "ale",     int'(ale_o),     0);
        chk("R9", "psen_n",  int'(psen_n_o),  1);
        chk("R9", "rd_n",    int'(rd_n_o),    1);
        chk("R9", "wr_n",    int'(wr_n_o),    1);
        chk("R9", "p0_oe",   int'(p0_oe_o),   0);
        chk("R9", "p0_out",  int'(p0_out_o),  0);
        chk("R9", "p2_out",  int'(p2_out_o),  0);
        chk("R9", "p2_addr", int'(p2_addr_o), 0);
        rst_n = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 10; i++) begin
                run_mc(kinds[i], addrs[i], wdats[i], pass[0]);
            end
        end
        // back-to-back data and fetch with mixed disable (R3 R4 R5)
        run_mc(4, 16'hBEEF, 16'h99, 1'b1);
        run_mc(1, 16'hBEEF, 0, 1'b0);
        run_mc(5, 16'h0042, 0, 1'b1);
        run_mc(2, 16'h80FF, 0, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule